// File: doc/BRIEF.md
# Descriptor Type Validity Checker

This block judges whether a fetched segment or gate descriptor has a type that the referencing context allows. The inputs are the descriptor's system flag and its 4-bit type field, plus a context code naming the instruction or internal step that made the reference. When a strobe is asserted, the block registers two results: a type-fault flag, and a transfer-class code. The class code is meaningful only for far call/jump references.

Each context has its own set of allowed types. For a far call or jump, an accepted descriptor is also sorted into one of three kinds of transfer: a direct move to another code segment, a transfer through a call gate, or a task switch. Descriptor fetching, privilege checks and the task-switch sequence itself are handled by other blocks.

Top module: `desc_type_chk`

## Requirements
- R1: Type encodings. With sysFlag=1, typeField bit 3 = 1 means a code segment and 0 means a data segment, and bit 2 of a code type marks it conforming. With sysFlag=0, the valid types are: LDT=0x2, task gate=0x5, available TSS=0x9, busy TSS=0xB, call gate=0xC, interrupt gate=0xE, trap gate=0xF. Every other system type is invalid in every context.
- R2: In the far call/jump context (ctxCode=0), the descriptor is accepted if it is any code segment, a call gate, a task gate, or a TSS (available or busy). Any other descriptor raises typeFault.
- R3: In the far call/jump context, xferClass is 01 for a code segment, 10 for a call gate, and 11 for a TSS or a task gate. When typeFault is set, xferClass is 00.
- R4: In every context other than far call/jump, xferClass is 00.
- R5: The load-LDT context (ctxCode=1) accepts only an LDT. The load-task-register context (ctxCode=2) accepts only a TSS, available or busy.
- R6: The load-access-rights context (ctxCode=3) accepts an LDT, a TSS, a call gate, a task gate, or any code or data segment.
- R7: The load-limit context (ctxCode=4) accepts an LDT, a TSS, or any code or data segment, and faults on every gate type.
- R8: The interrupt-table context (ctxCode=5) accepts only an interrupt gate, a trap gate or a task gate.
- R9: The gate-target context (ctxCode=6) accepts only a code segment. The task-target context (ctxCode=7) and the nested-return-link context (ctxCode=8) accept only a TSS. The unused context codes 9 to 15 always fault.
- R10: Results are registered. typeFault and xferClass update on the first clock edge after a cycle with strobe high, and they hold their values while strobe is low. After reset, typeFault=0 and xferClass=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Evaluate the current inputs |
| ctxCode | input | 4 | Referencing context |
| sysFlag | input | 1 | Descriptor system flag (1 = code or data segment) |
| typeField | input | 4 | Descriptor type field |
| typeFault | output | 1 | The type is not allowed in this context |
| xferClass | output | 2 | 00 none/fault, 01 direct code, 10 via call gate, 11 task switch |

## Verification
Both results are due exactly one clock edge after the cycle in which strobe is high. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It also runs cycles with strobe low and checks that both outputs keep the values latched by the previous strobe. A bench lookup function provides the expected values. The bench sweeps all 16 context codes against all 32 combinations of flag and type, then adds randomly ordered strobes.

// File: rtl/desc_chk_pkg.sv
package desc_chk_pkg;
  localparam int CtxW  = 4;
  localparam int TypeW = 4;
  localparam int ClsW  = 2;

  typedef enum logic [CtxW-1:0] {
    CtxFarXfer   = 4'd0,
    CtxLoadLdt   = 4'd1,
    CtxLoadTr    = 4'd2,
    CtxAccRights = 4'd3,
    CtxSegLimit  = 4'd4,
    CtxIntTable  = 4'd5,
    CtxGateTgt   = 4'd6,
    CtxTaskTgt   = 4'd7,
    CtxNestLink  = 4'd8
  } ctx_e;

  typedef enum logic [ClsW-1:0] {
    ClsNone = 2'b00,
    ClsCode = 2'b01,
    ClsGate = 2'b10,
    ClsTask = 2'b11
  } cls_e;

  // one-hot-ish descriptor kind flags decoded from flag+type
  typedef struct packed {
    logic isCode;
    logic isData;
    logic isLdt;
    logic isTss;
    logic isCallGate;
    logic isIntGate;
    logic isTrapGate;
    logic isTaskGate;
  } kind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic accept;
    cls_e cls;
  } ctl_t;
endpackage

// File: rtl/desc_chk_decode.sv
module desc_chk_decode
  import desc_chk_pkg::*;
(
  input  logic             sysFlag,
  input  logic [TypeW-1:0] typeField,
  output kind_t            kind
);
  always_comb begin
    kind = '0;
    if (sysFlag) begin
      kind.isCode = typeField[3];
      kind.isData = !typeField[3];
    end else begin
      unique case (typeField)
        4'h2:       kind.isLdt      = 1'b1;
        4'h9, 4'hB: kind.isTss      = 1'b1;
        4'hC:       kind.isCallGate = 1'b1;
        4'hE:       kind.isIntGate  = 1'b1;
        4'hF:       kind.isTrapGate = 1'b1;
        4'h5:       kind.isTaskGate = 1'b1;
        default:    ;
      endcase
    end
  end

  always_comb begin
    a_r1_kind_onehot: assert ($onehot0(kind));
  end
endmodule

// File: rtl/desc_chk_ctrl.sv
module desc_chk_ctrl
  import desc_chk_pkg::*;
(
  input  logic            strobe,
  input  logic [CtxW-1:0] ctxCode,
  input  kind_t           kind,
  output ctl_t            ctl
);
  logic okSel;
  logic anyGate;

  assign anyGate = kind.isCallGate | kind.isIntGate | kind.isTrapGate | kind.isTaskGate;

  always_comb begin
    unique case (ctxCode)
      CtxFarXfer:   okSel = kind.isCode | kind.isCallGate | kind.isTaskGate | kind.isTss;
      CtxLoadLdt:   okSel = kind.isLdt;
      CtxLoadTr:    okSel = kind.isTss;
      CtxAccRights: okSel = kind.isLdt | kind.isTss | kind.isCallGate | kind.isTaskGate
                            | kind.isCode | kind.isData;
      CtxSegLimit:  okSel = (kind.isLdt | kind.isTss | kind.isCode | kind.isData) & !anyGate;
      CtxIntTable:  okSel = kind.isIntGate | kind.isTrapGate | kind.isTaskGate;
      CtxGateTgt:   okSel = kind.isCode;
      CtxTaskTgt,
      CtxNestLink:  okSel = kind.isTss;
      default:      okSel = 1'b0;
    endcase
  end

  always_comb begin
    ctl.capture = strobe;
    ctl.accept  = okSel;
    ctl.cls     = ClsNone;
    if (okSel && ctxCode == CtxFarXfer) begin
      if (kind.isCode)          ctl.cls = ClsCode;
      else if (kind.isCallGate) ctl.cls = ClsGate;
      else                      ctl.cls = ClsTask;
    end
  end

  always_comb begin
    a_r4_cls_only_far: assert (ctxCode == CtxFarXfer || ctl.cls == ClsNone);
    a_r3_cls_needs_accept: assert (ctl.accept || ctl.cls == ClsNone);
  end
endmodule

// File: rtl/desc_chk_dp.sv
module desc_chk_dp
  import desc_chk_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctl_t            ctl,
  output logic            typeFault,
  output logic [ClsW-1:0] xferClass
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeFault <= 1'b0;
      xferClass <= ClsNone;
    end else if (ctl.capture) begin
      typeFault <= !ctl.accept;
      xferClass <= ctl.cls;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> ($stable(typeFault) && $stable(xferClass)));
  a_r3_fault_no_class: assert property (@(posedge clk) disable iff (!rstN)
    typeFault |-> xferClass == ClsNone);
  a_r10_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> typeFault == !$past(ctl.accept));
endmodule

// File: rtl/desc_type_chk.sv
module desc_type_chk
  import desc_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strobe,
  input  logic [3:0] ctxCode,
  input  logic       sysFlag,
  input  logic [3:0] typeField,
  output logic       typeFault,
  output logic [1:0] xferClass
);
  kind_t kind;
  ctl_t  ctl;

  desc_chk_decode uDec (.sysFlag(sysFlag), .typeField(typeField), .kind(kind));
  desc_chk_ctrl uCtl (.strobe(strobe), .ctxCode(ctxCode), .kind(kind), .ctl(ctl));
  desc_chk_dp uDp (.clk(clk), .rstN(rstN), .ctl(ctl),
                   .typeFault(typeFault), .xferClass(xferClass));
endmodule

// File: tb/tb_desc_type_chk.sv
module tb_desc_type_chk;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobe = 1'b0;
  logic [3:0] ctxCode = '0;
  logic sysFlag = 1'b0;
  logic [3:0] typeField = '0;
  logic typeFault;
  logic [1:0] xferClass;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  desc_type_chk dut (.clk(clk), .rstN(rstN), .strobe(strobe), .ctxCode(ctxCode),
    .sysFlag(sysFlag), .typeField(typeField), .typeFault(typeFault), .xferClass(xferClass));

  // Model built from the requirements: returns {fault, class}
  function automatic logic [2:0] model(input logic [3:0] c, input logic s, input logic [3:0] t);
    bit code, data, ldt, tss, cg, ig, tg, kg, ok;
    logic [1:0] cl;
    code = s && t[3];
    data = s && !t[3];
    ldt = !s && t == 4'h2;
    tss = !s && (t == 4'h9 || t == 4'hB);
    cg  = !s && t == 4'hC;
    ig  = !s && t == 4'hE;
    tg  = !s && t == 4'hF;
    kg  = !s && t == 4'h5;
    case (c)
      4'd0: ok = code || cg || kg || tss;        // R2
      4'd1: ok = ldt;                            // R5
      4'd2: ok = tss;                            // R5
      4'd3: ok = ldt || tss || cg || kg || code || data; // R6
      4'd4: ok = ldt || tss || code || data;     // R7
      4'd5: ok = ig || tg || kg;                 // R8
      4'd6: ok = code;                           // R9
      4'd7, 4'd8: ok = tss;                      // R9
      default: ok = 1'b0;                        // R9
    endcase
    cl = 2'b00;
    if (ok && c == 4'd0) cl = code ? 2'b01 : (cg ? 2'b10 : 2'b11); // R3
    return {!ok, cl};
  endfunction

  function automatic string reqOf(input logic [3:0] c);
    case (c)
      4'd0: return "R2/R3";
      4'd1, 4'd2: return "R5/R4";
      4'd3: return "R6/R4";
      4'd4: return "R7/R4";
      4'd5: return "R8/R4";
      default: return "R9/R1/R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if ({typeFault, xferClass} !== exp) begin
      fails++;
      $display("FAIL %s: got fault=%0b cls=%0b expected fault=%0b cls=%0b",
               req, typeFault, xferClass, exp[2], exp[1:0]);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic s, input logic [3:0] t);
    @(negedge clk);
    strobe = 1'b1; ctxCode = c; sysFlag = s; typeField = t;
    @(negedge clk);
    strobe = 1'b0;
    check(reqOf(c), model(c, s, t));
  endtask

  initial begin
    logic [2:0] last;
    repeat (3) @(negedge clk);
    check("R10 reset", 3'b000);
    rstN = 1'b1;
    // directed corners
    apply(4'd0, 1'b1, 4'hC);  // conforming code: R3 class 01
    apply(4'd0, 1'b0, 4'hC);  // call gate: R3 class 10
    apply(4'd0, 1'b0, 4'h5);  // task gate: R3 class 11
    apply(4'd0, 1'b0, 4'hB);  // busy TSS: R3 class 11
    apply(4'd0, 1'b1, 4'h2);  // data faults: R2
    apply(4'd4, 1'b0, 4'hC);  // R7 gate rejected
    apply(4'd0, 1'b0, 4'h1);  // R1 unlisted system type
    // hold check R10
    last = model(4'd0, 1'b0, 4'h1);
    @(negedge clk);
    ctxCode = 4'd0; sysFlag = 1'b1; typeField = 4'h8;
    repeat (2) @(negedge clk);
    check("R10 hold", last);
    // full sweep
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 32; k++)
        apply(c[3:0], k[4], k[3:0]);
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      apply(r[8:5], r[4], r[3:0]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule